// File: doc/BRIEF.md
# Host Strobe-Bus Slave Buffer

This block lets an external processor reach a 1024-word by 32-bit buffer inside the FPGA over an asynchronous, SRAM-style parallel bus. The host sees a memory device: it holds an active-low select, then pulses an active-low write strobe to store a word or an active-low output-enable strobe to read one. On-chip logic reaches the same storage at the same time through an independent synchronous port, so data can be handed between the processor and the fabric without arbitration.

All host strobes are brought into the single system clock domain (20 MHz in the target system) through a synchronizer before anything acts on them. The shared data lines are handled as a separate input, output and output-enable, and the tristate pad is placed outside this block by the chip top. The block drives the data lines only while a valid read is in progress, and it releases them quickly once the host ends the read or deselects the device.

Top module: `hbus_slave_buf`

## Requirements
- R1: While the synchronized chip select is low, a host write is a low pulse on `host_we_n` with `host_oe_n` high; the full word on `host_din` is stored at word `host_addr[9:0]` on the third clock edge after the raw rising edge of `host_we_n`, using address and data sampled while the synchronized write strobe was low.
- R2: A falling edge of `host_oe_n`, seen while chip select is low and `host_we_n` is high, raises `host_dout_en` exactly SYNC_STAGES+1+READ_LAT clock edges (5 with defaults) after the raw fall, with `host_dout` holding the word at `host_addr[9:0]`.
- R3: `host_dout_en` drops within SYNC_STAGES+1 clock edges (3 with defaults) after `host_oe_n` or `host_cs_n` rises, and is never high in the cycle after the synchronized chip select is seen high.
- R4: If write strobe and output enable are both seen low in the same access, the block neither stores a word nor drives the data lines for that access.
- R5: Address bits 15 to 10 are ignored: an access with any value there reaches the word selected by bits 9 to 0.
- R6: The byte-lane select input `host_lane_n` has no effect; every host write stores all 32 bits.
- R7: The internal port writes `int_wdata` at `int_addr` on a clock edge where `int_we` is high, and returns `int_rdata` one clock after the address; a read of the address being written in the same edge returns the old word.
- R8: When the host commit and an internal write hit the same word on the same clock edge, the host word is kept.
- R9: Host accesses may follow one another with chip select held low between them; each write is stored and each read drives the correct word.
- R10: During and after a synchronous active-low reset, `host_dout_en` is low and stays low until a valid read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_we_n | input | 1 | Host write strobe, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_addr | input | 16 | Host address; low 10 bits select the word |
| host_din | input | 32 | Data arriving from the shared data lines |
| host_lane_n | input | 4 | Byte-lane select from the host, ignored |
| host_dout | output | 32 | Data to place on the shared data lines |
| host_dout_en | output | 1 | Enables the external tristate driver |
| int_addr | input | 10 | Internal port word address |
| int_wdata | input | 32 | Internal port write data |
| int_we | input | 1 | Internal port write enable |
| int_rdata | output | 32 | Internal port read data, one clock after the address |

## Verification
Every host result is due a fixed number of clock edges after a raw strobe change: the drive enable rises on the fifth edge after an output-enable fall, falls by the third edge after output enable or chip select rises, and a write is stored on the third edge after the write strobe rises. The bench changes inputs on falling clock edges and counts rising edges from there, sampling the drive enable one edge before and exactly on the edge it is due, so an early or late turn-on is caught. Internal reads are sampled one edge after the address, and the collision case places the internal write on precisely the edge of the host commit. Constrained random traffic on a small address window mixes both ports, and all expected words come from a bench-side model of the storage.

// File: rtl/hbus_pkg.sv
// Shared types for the host strobe-bus slave buffer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package hbus_pkg;

    // Phase of a host read transaction
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_DRIVE = 2'd2
    } rd_phase_t;

endpackage

// File: rtl/hbus_strobe_sync.sv
// Multi-stage synchronizer for a group of active-low asynchronous strobes.
// Assumes each bit is an independent level; reset forces the inactive (high) level.
module hbus_strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Later stages settle the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_host_ctrl.sv
// Host-side control: turns synchronized strobes into a single write commit per
// write pulse and a timed read drive window. Assumes the raw address and data
// stay stable while the strobes that qualify them are low, plus two clocks.
module hbus_host_ctrl
    import hbus_pkg::*;
#(
    parameter int AW       = 10,
    parameter int DW       = 32,
    parameter int READ_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic [AW-1:0] addr_raw,
    input  logic [DW-1:0] din_raw,
    output logic          mem_wr,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          dout_en
);

    localparam int CW = (READ_LAT > 1) ? $clog2(READ_LAT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(READ_LAT - 1);

    logic          we_prev, oe_prev;
    logic          armed, bad;
    logic [AW-1:0] cap_addr, raddr;
    logic [DW-1:0] cap_data;
    logic [CW-1:0] cnt;
    rd_phase_t     phase;
    logic          we_rise, oe_fall, rd_abort, wr_phase;

    assign we_rise  = we_s & ~we_prev;
    assign oe_fall  = ~oe_s & oe_prev;
    assign wr_phase = ~cs_s & ~we_s;
    assign rd_abort = oe_s | cs_s | ~we_s;

    // Edge history of the synchronized strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
            oe_prev <= 1'b1;
        end else begin
            we_prev <= we_s;
            oe_prev <= oe_s;
        end
    end

    // Capture write address/data while the write strobe is low; flag a clash with output enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            bad      <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else if (we_rise) begin
            armed <= 1'b0;
            bad   <= 1'b0;
        end else if (wr_phase) begin
            if (oe_s) begin
                armed    <= 1'b1;
                cap_addr <= addr_raw;
                cap_data <= din_raw;
            end else begin
                bad <= 1'b1;
            end
        end
    end

    assign mem_wr    = we_rise & armed & ~bad & ~cs_s;
    assign mem_waddr = cap_addr;
    assign mem_wdata = cap_data;

    // Read phase sequencer: wait READ_LAT clocks, then drive until a strobe ends the read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= RD_IDLE;
            cnt   <= '0;
            raddr <= '0;
        end else begin
            case (phase)
                RD_IDLE: begin
                    if (oe_fall && !cs_s && we_s) begin
                        phase <= RD_WAIT;
                        cnt   <= '0;
                        raddr <= addr_raw;
                    end
                end
                RD_WAIT: begin
                    if (rd_abort)              phase <= RD_IDLE;
                    else if (cnt == CNT_LAST)  phase <= RD_DRIVE;
                    else                       cnt   <= cnt + 1'b1;
                end
                RD_DRIVE: begin
                    if (rd_abort) phase <= RD_IDLE;
                end
                default: phase <= RD_IDLE;
            endcase
        end
    end

    assign mem_raddr = raddr;
    assign dout_en   = (phase == RD_DRIVE);

endmodule

// File: rtl/hbus_dpram.sv
// Two-port word storage: host port with separate write and read addresses,
// internal port with one shared address. Reads are registered and return the
// old word on a same-edge write. A same-address double write keeps the host word.
module hbus_dpram #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_waddr,
    input  logic [DW-1:0] h_wdata,
    input  logic [AW-1:0] h_raddr,
    output logic [DW-1:0] h_rdata,
    input  logic          i_we,
    input  logic [AW-1:0] i_addr,
    input  logic [DW-1:0] i_wdata,
    output logic [DW-1:0] i_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          i_blocked;

    assign i_blocked = h_we && (h_waddr == i_addr);

    // Writes from both ports, host first on a shared address
    always_ff @(posedge clk) begin
        if (i_we && !i_blocked) mem[i_addr] <= i_wdata;
        if (h_we)               mem[h_waddr] <= h_wdata;
    end

    // Registered reads for both ports
    always_ff @(posedge clk) begin
        h_rdata <= mem[h_raddr];
        i_rdata <= mem[i_addr];
    end

endmodule

// File: rtl/hbus_slave_buf.sv
// Top of the host strobe-bus slave buffer. Synchronizes the host strobes,
// sequences host reads and writes, and shares storage with on-chip logic.
// Assumes the tristate pad for the data lines lives in the chip top.
module hbus_slave_buf #(
    parameter int HOST_AW     = 16,
    parameter int DW          = 32,
    parameter int WORD_AW     = 10,
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int READ_LAT    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs_n,
    input  logic               host_we_n,
    input  logic               host_oe_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_din,
    input  logic [LANES-1:0]   host_lane_n,
    output logic [DW-1:0]      host_dout,
    output logic               host_dout_en,
    input  logic [WORD_AW-1:0] int_addr,
    input  logic [DW-1:0]      int_wdata,
    input  logic               int_we,
    output logic [DW-1:0]      int_rdata
);

    logic [2:0]         strobes_s;
    logic               cs_s, we_s, oe_s;
    logic               host_wr;
    logic [WORD_AW-1:0] host_waddr, host_raddr;
    logic [DW-1:0]      host_wdata;
    logic               unused_inputs;

    // Lane selects and upper address bits carry no meaning for full-word storage
    assign unused_inputs = ^{host_lane_n, host_addr[HOST_AW-1:WORD_AW]};

    hbus_strobe_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_cs_n, host_we_n, host_oe_n}),
        .sync_out (strobes_s)
    );

    assign {cs_s, we_s, oe_s} = strobes_s;

    hbus_host_ctrl #(
        .AW       (WORD_AW),
        .DW       (DW),
        .READ_LAT (READ_LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .we_s      (we_s),
        .oe_s      (oe_s),
        .addr_raw  (host_addr[WORD_AW-1:0]),
        .din_raw   (host_din),
        .mem_wr    (host_wr),
        .mem_waddr (host_waddr),
        .mem_wdata (host_wdata),
        .mem_raddr (host_raddr),
        .dout_en   (host_dout_en)
    );

    hbus_dpram #(
        .AW (WORD_AW),
        .DW (DW)
    ) u_ram (
        .clk     (clk),
        .h_we    (host_wr),
        .h_waddr (host_waddr),
        .h_wdata (host_wdata),
        .h_raddr (host_raddr),
        .h_rdata (host_dout),
        .i_we    (int_we),
        .i_addr  (int_addr),
        .i_wdata (int_wdata),
        .i_rdata (int_rdata)
    );

endmodule

// File: rtl/hbus_slave_buf_chk.sv
// Protocol checker for the host strobe-bus slave buffer, bound to the top.
// Assumes synchronized strobes reset to the inactive level.
module hbus_slave_buf_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic we_s,
    input logic oe_s,
    input logic host_wr,
    input logic host_dout_en
);

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !host_dout_en); // R3

    AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |=> !host_dout_en); // R4

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        host_dout_en |-> !$past(oe_s)); // R2

    AST_COMMIT_ON_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |-> (we_s && !$past(we_s))); // R1

    AST_NO_COMMIT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |-> !host_dout_en); // R4

    AST_DRIVE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(host_dout_en)); // R10

endmodule

bind hbus_slave_buf hbus_slave_buf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_s         (cs_s),
    .we_s         (we_s),
    .oe_s         (oe_s),
    .host_wr      (host_wr),
    .host_dout_en (host_dout_en)
);

// File: tb/hbus_slave_buf_tb.sv
// Bench for the host strobe-bus slave buffer: directed corners plus seeded random traffic.
module hbus_slave_buf_tb;

    localparam int CLK_PERIOD = 50;
    localparam int SEED       = 32'h5eed_0a17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [31:0] din = '0;
    logic [3:0]  lane_n = '1;
    logic [31:0] dout;
    logic        dout_en;
    logic [9:0]  i_addr = '0;
    logic [31:0] i_wdata = '0;
    logic        i_we = 1'b0;
    logic [31:0] i_rdata;

    int tests = 0;
    int fails = 0;

    logic [31:0] model [1024];
    bit          valid [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_slave_buf u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_cs_n    (cs_n),
        .host_we_n    (we_n),
        .host_oe_n    (oe_n),
        .host_addr    (addr),
        .host_din     (din),
        .host_lane_n  (lane_n),
        .host_dout    (dout),
        .host_dout_en (dout_en),
        .int_addr     (i_addr),
        .int_wdata    (i_wdata),
        .int_we       (i_we),
        .int_rdata    (i_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [9:0] a, input int salt);
        return {a, 22'(salt)} ^ 32'hA5C3_0F19;
    endfunction

    // Host write; stored on the third edge after the write strobe rises
    task automatic host_write(input logic [15:0] a, input logic [31:0] d, input bit keep_cs);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; addr = a; din = d; lane_n = 4'($urandom()); we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        if (!keep_cs) cs_n = 1'b1;
        model[a[9:0]] = d;
        valid[a[9:0]] = 1'b1;
    endtask

    // Host read with exact drive-enable timing checks
    task automatic host_read(input logic [15:0] a, input bit keep_cs, input string tag);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b1; addr = a; oe_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dout_en == 1'b0, {tag, " R2 drive before due"}, 32'(dout_en), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(dout_en == 1'b1, {tag, " R2 drive on time"}, 32'(dout_en), 32'd1);
        if (valid[a[9:0]])
            chk(dout == model[a[9:0]], {tag, " R2 read word"}, dout, model[a[9:0]]);
        oe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout_en == 1'b0, {tag, " R3 release after oe"}, 32'(dout_en), 32'd0);
        if (!keep_cs) cs_n = 1'b1;
    endtask

    task automatic int_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        i_addr = a; i_wdata = d; i_we = 1'b1;
        @(negedge clk);
        i_we = 1'b0;
        model[a] = d;
        valid[a] = 1'b1;
    endtask

    task automatic int_read(input logic [9:0] a, input string tag);
        @(negedge clk);
        i_addr = a;
        @(posedge clk);
        @(negedge clk);
        if (valid[a]) chk(i_rdata == model[a], tag, i_rdata, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        for (int k = 0; k < 1024; k++) valid[k] = 1'b0;

        // R10: reset state
        repeat (5) @(negedge clk);
        chk(dout_en == 1'b0, "R10 drive low in reset", 32'(dout_en), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R10 drive low after reset", 32'(dout_en), 32'd0);

        // R1, R6: host write with random lane selects, read via internal port
        host_write(16'h0003, 32'hDEAD_BEEF, 1'b0);
        int_read(10'h003, "R1 R6 host write full word");

        // R2: host read of that word
        host_read(16'h0003, 1'b0, "basic");

        // R5: upper address bits ignored
        host_write(16'hFC05, 32'h1234_5678, 1'b0);
        int_read(10'h005, "R5 upper bits ignored on write");
        host_read(16'h8005, 1'b0, "R5 alias");

        // R3: deselected, output enable low, no drive
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = 16'h0003;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(dout_en == 1'b0, "R3 no drive while deselected", 32'(dout_en), 32'd0);
        end
        oe_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3: chip select rising ends a read
        @(negedge clk);
        cs_n = 1'b0; addr = 16'h0003; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(dout_en == 1'b1, "R2 drive before cs release", 32'(dout_en), 32'd1);
        cs_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout_en == 1'b0, "R3 release after cs", 32'(dout_en), 32'd0);
        oe_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: both strobes low, no write and no drive
        @(negedge clk);
        cs_n = 1'b0; addr = 16'h0003; din = 32'h0BAD_0BAD; we_n = 1'b0; oe_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(dout_en == 1'b0, "R4 no drive on clash", 32'(dout_en), 32'd0);
        end
        we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        int_read(10'h003, "R4 no write on clash");

        // R7: internal write, read-before-write on the same edge
        int_write(10'h040, 32'hCAFE_0001);
        @(negedge clk);
        i_addr = 10'h040; i_wdata = 32'hCAFE_0002; i_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(i_rdata == 32'hCAFE_0001, "R7 old word on same-edge write", i_rdata, 32'hCAFE_0001);
        i_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(i_rdata == 32'hCAFE_0002, "R7 new word after write", i_rdata, 32'hCAFE_0002);
        model[10'h040] = 32'hCAFE_0002;
        host_read(16'h0040, 1'b0, "R7 host sees internal write");

        // R8: same-edge collision, host wins
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; addr = 16'h0077; din = 32'h4057_4057; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        i_addr = 10'h077; i_wdata = 32'h1111_2222; i_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        i_we = 1'b0; cs_n = 1'b1;
        model[10'h077] = 32'h4057_4057;
        valid[10'h077] = 1'b1;
        int_read(10'h077, "R8 host wins collision");

        // R9: back-to-back host accesses with chip select held low
        host_write(16'h0100, 32'h0000_AAAA, 1'b1);
        host_write(16'h0101, 32'h0000_BBBB, 1'b1);
        host_read(16'h0100, 1'b1, "R9 b2b read 1");
        host_read(16'h0101, 1'b1, "R9 b2b read 2");
        host_write(16'h0100, 32'h0000_CCCC, 1'b1);
        host_read(16'h0100, 1'b0, "R9 b2b read after write");

        // Random mix of both ports on a small window
        for (int n = 0; n < 60; n++) begin
            logic [9:0] a;
            int op;
            a  = 10'($urandom_range(0, 15));
            op = $urandom_range(0, 3);
            case (op)
                0: host_write({6'($urandom()), a}, mk_word(a, n), 1'($urandom_range(0, 1)));
                1: host_read({6'($urandom()), a}, 1'b0, "rand R2");
                2: int_write(a, mk_word(a, n + 1000));
                default: int_read(a, "rand R7");
            endcase
        end

        @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dout_en == 1'b0, "R3 idle at end", 32'(dout_en), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule